// File: doc/BRIEF.md
# Scanline Bus-Event Scheduler

This block decides, clock by clock, when bus transfers and memory stalls may take the CPU bus during a video line. It follows the horizontal clock position within the line. Three events are tied to that position. An HDMA table initialisation fires on the first line of each frame. An HDMA line transfer fires on each visible line. A DRAM refresh stall of fixed length fires on every line. Where the init and refresh events fall depends on a chip-revision select and on a running 8-clock transfer phase. That phase carries on from line to line, because the accumulator absorbs each line's length modulo 8.

Events and general DMA requests are only acted on at CPU cycle edges. A small arbiter serves HDMA before DMA. It delays each transfer start until the 8-clock phase boundary and issues a one-cycle grant. The transfer datapaths themselves are outside this block. Before the CPU resumes, the arbiter holds a resync stall that realigns the CPU to its own cycle length.

Top module: `scanline_bus_sched`

## Requirements
- R1: Transfer phase is (acc + hpos) mod 8. The accumulator acc starts at 0 after reset. At every line start (hpos == 0) it adds the previous line's `line_len`, mod 8; the value used before the first line is 1364. Every grant is asserted in the cycle just before an edge at which this phase is 0.
- R2: On a line with `vcount` == 0, an HDMA-init event fires at position 20 − p when `rev_sel` = 0, or 12 + p when `rev_sel` = 1. Here p is the phase at that line's start. It fires on no other line.
- R3: `stall_refresh` rises in the cycle that follows the edge at which hpos equals the refresh position, and stays high for 40 cycles. The refresh position is 530 when `rev_sel` = 0 and 538 − p when `rev_sel` = 1.
- R4: An HDMA-run event fires at position 1104 only when `vcount` ≤ 224, or `vcount` ≤ 239 while `overscan` = 1.
- R5: An init event makes HDMA pending only if `hdma_en_any` = 1, and a run event only if `hdma_act_any` = 1. Pending events are held until an edge with `cycle_edge` = 1 processes them. The edge moves the idle arbiter to its run state.
- R6: In the run state, pending HDMA is served before DMA. Each start waits 8 − phase clocks and is taken only if its channels are enabled. An HDMA grant is followed by the DMA grant 8 cycles later when `dma_en_any` = 1.
- R7: After the last grant, `resync_len` = L − (n mod L). Here L is `cpu_cycle_len` and n is the number of clock edges spent in the run and wait states. `stall_resync` is then high for exactly `resync_len` cycles, with no grant in that time. A run state with nothing enabled leaves at once, with n = 1.
- R8: During and right after reset, all stalls and grants are 0 and `resync_len` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, one tick per horizontal clock |
| rst | input | 1 | Synchronous active-high reset |
| hpos | input | 11 | Horizontal clock position in the line; 0 marks a line start |
| vcount | input | 9 | Current line number, constant across a line |
| overscan | input | 1 | Extends the visible-line limit from 224 to 239 |
| line_len | input | 11 | Clock length of the line that starts at hpos 0 |
| rev_sel | input | 1 | Chip revision: 0 = first, 1 = second |
| cpu_cycle_len | input | 4 | Length of the current CPU cycle in clocks (2..15) |
| hdma_en_any | input | 1 | At least one HDMA channel enabled |
| hdma_act_any | input | 1 | At least one HDMA channel still active this frame |
| dma_en_any | input | 1 | At least one general DMA channel enabled |
| dma_req | input | 1 | Pulse: general DMA requested |
| cycle_edge | input | 1 | CPU cycle edge strobe |
| stall_refresh | output | 1 | DRAM refresh stall in progress |
| stall_resync | output | 1 | CPU resync stall in progress |
| hdma_init_go | output | 1 | One-cycle grant: start HDMA initialisation |
| hdma_run_go | output | 1 | One-cycle grant: start HDMA line transfer |
| dma_go | output | 1 | One-cycle grant: start general DMA |
| resync_len | output | 4 | Length of the last resync stall |

## Verification
Timing is counted from the edge at which an event position or a request is applied. The event pulse registers one cycle later. An edge with `cycle_edge` set moves the arbiter to run one more cycle after that. From the run edge, the grant appears at the first position h where phase(h + 1) is 0. The resync stall is then visible from h + 1 for `resync_len` samples. The refresh stall is visible starting at the sample of the refresh position. The bench holds its own model of the phase accumulator. It records the hpos of every grant and stall edge, sampling one time step after each rising edge, and compares the recorded positions and lengths with the values derived from these counts.

// File: rtl/sched_pkg.sv
package sched_pkg;

    localparam int HPOS_W       = 11;
    localparam int VPOS_W       = 9;
    localparam int CYC_W        = 4;
    localparam int PHASE_W      = 3;
    localparam int LINE_DEF     = 1364;
    localparam int INIT_BASE    = 12;
    localparam int REFRESH_BASE = 530;
    localparam int REFRESH_CLKS = 40;
    localparam int RUN_POS      = 1104;
    localparam int LAST_VIS     = 224;
    localparam int LAST_VIS_OS  = 239;

    typedef enum logic [2:0] {
        ARB_IDLE,
        ARB_RUN,
        ARB_WAIT_H,
        ARB_WAIT_D,
        ARB_SYNC
    } arb_state_e;

    typedef struct packed {
        logic init;
        logic run;
    } edge_flags_t;

    function automatic logic [HPOS_W-1:0] init_position(input logic rev, input logic [PHASE_W-1:0] p);
        return rev ? (HPOS_W'(INIT_BASE) + HPOS_W'(p))
                   : (HPOS_W'(INIT_BASE + 8) - HPOS_W'(p));
    endfunction

    function automatic logic [HPOS_W-1:0] refresh_position(input logic rev, input logic [PHASE_W-1:0] p);
        return rev ? (HPOS_W'(REFRESH_BASE + 8) - HPOS_W'(p))
                   : HPOS_W'(REFRESH_BASE);
    endfunction

endpackage

// File: rtl/sched_phase.sv
module sched_phase
    import sched_pkg::*;
#(
    parameter int LEN_W   = HPOS_W,
    parameter int LEN_DEF = LINE_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [LEN_W-1:0]   hpos,
    input  logic [LEN_W-1:0]   line_len,
    output logic               line_start,
    output logic [PHASE_W-1:0] phase,
    output logic [PHASE_W-1:0] line_phase
);

    logic [PHASE_W-1:0] acc;
    logic [LEN_W-1:0]   len_q;
    logic [PHASE_W-1:0] acc_next;

    assign line_start = (hpos == '0);
    assign acc_next   = PHASE_W'(LEN_W'(acc) + len_q);
    assign line_phase = acc_next;
    // continuous across the wrap: new accumulator is used on the start cycle
    assign phase      = line_start ? acc_next : PHASE_W'(LEN_W'(acc) + hpos);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= '0;
            len_q <= LEN_W'(LEN_DEF);
        end else if (line_start) begin
            acc   <= acc_next;
            len_q <= line_len;
        end
    end

endmodule

// File: rtl/sched_events.sv
module sched_events
    import sched_pkg::*;
#(
    parameter int POS_W   = HPOS_W,
    parameter int LINE_W  = VPOS_W,
    parameter int REF_LEN = REFRESH_CLKS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [POS_W-1:0]   hpos,
    input  logic [LINE_W-1:0]  vcount,
    input  logic               overscan,
    input  logic               rev_sel,
    input  logic               line_start,
    input  logic [PHASE_W-1:0] line_phase,
    output logic               ev_init,
    output logic               ev_run,
    output logic               stall_refresh
);

    localparam int RCNT_W = $clog2(REF_LEN + 1);

    logic [POS_W-1:0]  init_pos, ref_pos;
    logic              init_arm, run_arm, ref_arm;
    logic [RCNT_W-1:0] ref_cnt;
    logic              visible;

    assign visible       = overscan ? (vcount <= LINE_W'(LAST_VIS_OS)) : (vcount <= LINE_W'(LAST_VIS));
    assign stall_refresh = (ref_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ev_init  <= 1'b0;
            ev_run   <= 1'b0;
            init_arm <= 1'b0;
            run_arm  <= 1'b0;
            ref_arm  <= 1'b1;
            init_pos <= '0;
            ref_pos  <= refresh_position(rev_sel, '0);
            ref_cnt  <= '0;
        end else begin
            ev_init <= 1'b0;
            ev_run  <= 1'b0;
            if (ref_cnt != '0) ref_cnt <= ref_cnt - 1'b1;
            if (line_start) begin
                init_pos <= init_position(rev_sel, line_phase);
                ref_pos  <= refresh_position(rev_sel, line_phase);
                init_arm <= (vcount == '0);
                run_arm  <= visible;
                ref_arm  <= 1'b1;
            end else begin
                if (init_arm && hpos == init_pos) begin
                    ev_init  <= 1'b1;
                    init_arm <= 1'b0;
                end
                if (run_arm && hpos == POS_W'(RUN_POS)) begin
                    ev_run  <= 1'b1;
                    run_arm <= 1'b0;
                end
                if (ref_arm && hpos == ref_pos) begin
                    ref_cnt <= RCNT_W'(REF_LEN);
                    ref_arm <= 1'b0;
                end
            end
        end
    end

    AST_INIT_ON_FIRST_LINE: assert property (@(posedge clk) disable iff (rst)
        ev_init |-> vcount == '0);                                          // R2
    AST_RUN_AT_FIXED_POS: assert property (@(posedge clk) disable iff (rst)
        ev_run |-> $past(hpos) == POS_W'(RUN_POS));                         // R4

endmodule

// File: rtl/sched_arbiter.sv
module sched_arbiter
    import sched_pkg::*;
#(
    parameter int CW = CYC_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] phase,
    input  logic               cycle_edge,
    input  logic               ev_init,
    input  logic               ev_run,
    input  logic               hdma_en_any,
    input  logic               hdma_act_any,
    input  logic               dma_en_any,
    input  logic               dma_req,
    input  logic [CW-1:0]      cpu_cycle_len,
    output logic               hdma_init_go,
    output logic               hdma_run_go,
    output logic               dma_go,
    output logic               stall_resync,
    output logic [CW-1:0]      resync_len
);

    arb_state_e    state;
    edge_flags_t   flags;
    logic          hpend, hmode_init, dpend, cur_init;
    logic [3:0]    wcnt;
    logic [CW-1:0] dclk, scnt;

    logic          eff_init, eff_run, take_init, take_run, hp_set;
    logic [CW:0]   dsum;
    logic [CW-1:0] dclk_inc, sync_len;
    logic [3:0]    wait_len;
    logic          grant_slot;

    always_comb begin
        eff_init  = flags.init | ev_init;
        eff_run   = flags.run  | ev_run;
        take_init = cycle_edge & eff_init & hdma_en_any;
        take_run  = cycle_edge & eff_run  & hdma_act_any;
        hp_set    = take_init | take_run;
        dsum      = {1'b0, dclk} + 1'b1;
        dclk_inc  = (dsum == {1'b0, cpu_cycle_len}) ? '0 : dsum[CW-1:0];
        sync_len  = cpu_cycle_len - dclk_inc;
        wait_len  = 4'd8 - {1'b0, phase};
        grant_slot = (wcnt == 4'd1);
    end

    assign hdma_init_go = (state == ARB_WAIT_H) && grant_slot && cur_init;
    assign hdma_run_go  = (state == ARB_WAIT_H) && grant_slot && !cur_init;
    assign dma_go       = (state == ARB_WAIT_D) && grant_slot;
    assign stall_resync = (state == ARB_SYNC);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ARB_IDLE;
            flags      <= '0;
            hpend      <= 1'b0;
            hmode_init <= 1'b0;
            dpend      <= 1'b0;
            cur_init   <= 1'b0;
            wcnt       <= '0;
            dclk       <= '0;
            scnt       <= '0;
            resync_len <= '0;
        end else begin
            if (state == ARB_RUN || state == ARB_WAIT_H || state == ARB_WAIT_D)
                dclk <= dclk_inc;
            unique case (state)
                ARB_IDLE: if (cycle_edge && (dpend || dma_req || hpend || hp_set)) begin
                    state <= ARB_RUN;
                    dclk  <= '0;
                end
                ARB_RUN: begin
                    hpend <= 1'b0;
                    if (hpend && hdma_en_any) begin
                        cur_init <= hmode_init;
                        wcnt     <= wait_len;
                        state    <= ARB_WAIT_H;
                    end else if (dpend && dma_en_any) begin
                        dpend <= 1'b0;
                        wcnt  <= wait_len;
                        state <= ARB_WAIT_D;
                    end else begin
                        dpend      <= 1'b0;
                        resync_len <= sync_len;
                        scnt       <= sync_len;
                        state      <= ARB_SYNC;
                    end
                end
                ARB_WAIT_H: if (grant_slot) begin
                    if (dma_en_any) state <= ARB_RUN;
                    else begin
                        resync_len <= sync_len;
                        scnt       <= sync_len;
                        state      <= ARB_SYNC;
                    end
                end else wcnt <= wcnt - 1'b1;
                ARB_WAIT_D: if (grant_slot) begin
                    resync_len <= sync_len;
                    scnt       <= sync_len;
                    state      <= ARB_SYNC;
                end else wcnt <= wcnt - 1'b1;
                ARB_SYNC: if (scnt == CW'(1)) state <= ARB_IDLE;
                          else scnt <= scnt - 1'b1;
                default: state <= ARB_IDLE;
            endcase
            // event flags: held until a cycle edge consumes them, lowest bit first
            if (cycle_edge) flags <= '0;
            else begin
                flags.init <= eff_init;
                flags.run  <= eff_run;
            end
            if (dma_req) dpend <= 1'b1;
            if (hp_set) begin
                hpend      <= 1'b1;
                hmode_init <= !take_run;
            end
        end
    end

    AST_GRANT_ON_PHASE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (hdma_init_go || hdma_run_go || dma_go) |-> phase == '0);            // R1
    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hdma_init_go, hdma_run_go, dma_go}));                      // R6
    AST_SYNC_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
        stall_resync |-> (resync_len != '0 && resync_len <= cpu_cycle_len)); // R7
    AST_NO_GRANT_IN_SYNC: assert property (@(posedge clk) disable iff (rst)
        stall_resync |-> !(hdma_init_go || hdma_run_go || dma_go));          // R7

endmodule

// File: rtl/scanline_bus_sched.sv
module scanline_bus_sched
    import sched_pkg::*;
#(
    parameter int HW = HPOS_W,
    parameter int VW = VPOS_W,
    parameter int CW = CYC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [HW-1:0] hpos,
    input  logic [VW-1:0] vcount,
    input  logic          overscan,
    input  logic [HW-1:0] line_len,
    input  logic          rev_sel,
    input  logic [CW-1:0] cpu_cycle_len,
    input  logic          hdma_en_any,
    input  logic          hdma_act_any,
    input  logic          dma_en_any,
    input  logic          dma_req,
    input  logic          cycle_edge,
    output logic          stall_refresh,
    output logic          stall_resync,
    output logic          hdma_init_go,
    output logic          hdma_run_go,
    output logic          dma_go,
    output logic [CW-1:0] resync_len
);

    logic               line_start;
    logic [PHASE_W-1:0] phase, line_phase;
    logic               ev_init, ev_run;

    sched_phase #(.LEN_W(HW), .LEN_DEF(LINE_DEF)) u_phase (
        .clk(clk), .rst(rst), .hpos(hpos), .line_len(line_len),
        .line_start(line_start), .phase(phase), .line_phase(line_phase)
    );

    sched_events #(.POS_W(HW), .LINE_W(VW), .REF_LEN(REFRESH_CLKS)) u_events (
        .clk(clk), .rst(rst), .hpos(hpos), .vcount(vcount), .overscan(overscan),
        .rev_sel(rev_sel), .line_start(line_start), .line_phase(line_phase),
        .ev_init(ev_init), .ev_run(ev_run), .stall_refresh(stall_refresh)
    );

    sched_arbiter #(.CW(CW)) u_arb (
        .clk(clk), .rst(rst), .phase(phase), .cycle_edge(cycle_edge),
        .ev_init(ev_init), .ev_run(ev_run), .hdma_en_any(hdma_en_any),
        .hdma_act_any(hdma_act_any), .dma_en_any(dma_en_any), .dma_req(dma_req),
        .cpu_cycle_len(cpu_cycle_len), .hdma_init_go(hdma_init_go),
        .hdma_run_go(hdma_run_go), .dma_go(dma_go),
        .stall_resync(stall_resync), .resync_len(resync_len)
    );

endmodule

// File: tb/scanline_bus_sched_bench.sv
module scanline_bus_sched_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] hpos = '0;
    logic [8:0]  vcount = '0;
    logic        overscan = 1'b0;
    logic [10:0] line_len = 11'd1364;
    logic        rev_sel = 1'b0;
    logic [3:0]  cpu_cycle_len = 4'd6;
    logic        hdma_en_any = 1'b0, hdma_act_any = 1'b0, dma_en_any = 1'b0;
    logic        dma_req = 1'b0, cycle_edge = 1'b0;
    logic        stall_refresh, stall_resync, hdma_init_go, hdma_run_go, dma_go;
    logic [3:0]  resync_len;

    always #4 clk = ~clk;

    scanline_bus_sched u_scanline_bus_sched (
        .clk(clk), .rst(rst), .hpos(hpos), .vcount(vcount), .overscan(overscan),
        .line_len(line_len), .rev_sel(rev_sel), .cpu_cycle_len(cpu_cycle_len),
        .hdma_en_any(hdma_en_any), .hdma_act_any(hdma_act_any), .dma_en_any(dma_en_any),
        .dma_req(dma_req), .cycle_edge(cycle_edge), .stall_refresh(stall_refresh),
        .stall_resync(stall_resync), .hdma_init_go(hdma_init_go), .hdma_run_go(hdma_run_go),
        .dma_go(dma_go), .resync_len(resync_len)
    );

    int errors = 0, checks = 0;
    bit done = 0;
    int acc_m = 0, prev_len = 1364;
    int init_h, run_h, dma_h, ref_h, ref_n;
    int rs_w[3], cnt_w[3];

    // vector table: stimulus and expected presence of the two HDMA grants
    localparam int NV = 10;
    localparam int TV_V   [NV] = '{0,    0,    1,    224,  225,  225,  239,  240,  0,    0};
    localparam int TV_OS  [NV] = '{0,    0,    0,    0,    0,    1,    1,    1,    0,    0};
    localparam int TV_REV [NV] = '{0,    1,    1,    0,    1,    0,    1,    0,    1,    0};
    localparam int TV_LEN [NV] = '{1364, 1362, 1365, 1363, 1364, 1361, 1364, 1366, 1364, 1364};
    localparam int TV_HEN [NV] = '{1,    1,    1,    1,    1,    1,    1,    1,    0,    1};
    localparam int TV_HACT[NV] = '{1,    1,    1,    1,    1,    1,    1,    1,    0,    0};
    localparam int TV_CYC [NV] = '{6,    8,    12,   6,    8,    12,   6,    8,    8,    6};
    localparam int TV_EI  [NV] = '{1,    1,    0,    0,    0,    0,    0,    0,    0,    1};
    localparam int TV_ER  [NV] = '{1,    1,    1,    1,    0,    1,    1,    0,    0,    0};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int first_slot(input int from);
        int h = from;
        while (((acc_m + h + 1) % 8) != 0) h++;
        return h;
    endfunction

    function automatic int resync_of(input int r, input int last_g, input int l);
        int n = last_g + 2 - r;
        return l - (n % l);
    endfunction

    task automatic run_line(input int v, input int os, input int rev, input int len,
                            input int hen, input int hact, input int den, input int cyc,
                            input int dma_at, input int edge_from);
        bit prev_ref = 0;
        acc_m = (acc_m + prev_len) % 8;
        prev_len = len;
        init_h = -1; run_h = -1; dma_h = -1; ref_h = -1; ref_n = 0;
        for (int w = 0; w < 3; w++) begin rs_w[w] = -1; cnt_w[w] = 0; end
        vcount = 9'(v); overscan = os[0]; rev_sel = rev[0]; line_len = 11'(len);
        hdma_en_any = hen[0]; hdma_act_any = hact[0]; dma_en_any = den[0];
        cpu_cycle_len = 4'(cyc);
        for (int h = 0; h < len; h++) begin
            hpos = 11'(h);
            dma_req = (h == dma_at);
            cycle_edge = (h >= edge_from);
            @(posedge clk); #1;
            if (hdma_init_go && init_h < 0) init_h = h;
            if (hdma_run_go && run_h < 0) run_h = h;
            if (dma_go && dma_h < 0) dma_h = h;
            if (stall_refresh && !prev_ref && ref_h < 0) ref_h = h;
            if (stall_refresh) ref_n++;
            prev_ref = stall_refresh;
            if (stall_resync) begin
                int w = (h < 150) ? 0 : (h < 1000) ? 1 : 2;
                if (rs_w[w] < 0) rs_w[w] = int'(resync_len);
                cnt_w[w]++;
            end
        end
        dma_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R8: reset state
        chk(!stall_refresh && !stall_resync, "R8 stalls in reset", int'({stall_refresh, stall_resync}), 0);
        chk(!hdma_init_go && !hdma_run_go && !dma_go, "R8 grants in reset",
            int'({hdma_init_go, hdma_run_go, dma_go}), 0);
        chk(resync_len == 0, "R8 resync_len in reset", int'(resync_len), 0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            int p, e, exp_g, r, exp_ref;
            run_line(TV_V[i], TV_OS[i], TV_REV[i], TV_LEN[i], TV_HEN[i], TV_HACT[i], 0,
                     TV_CYC[i], -1, 0);
            p = acc_m;
            e = (TV_REV[i] != 0) ? 12 + p : 20 - p;
            // R2 / R1: init grant position
            if (TV_EI[i] != 0) begin
                r = e + 2;
                exp_g = first_slot(r);
                chk(init_h == exp_g, "R2 R1 init grant position", init_h, exp_g);
                chk(rs_w[0] == resync_of(r, exp_g, TV_CYC[i]), "R7 init resync_len", rs_w[0],
                    resync_of(r, exp_g, TV_CYC[i]));
                chk(cnt_w[0] == resync_of(r, exp_g, TV_CYC[i]), "R7 init stall length", cnt_w[0],
                    resync_of(r, exp_g, TV_CYC[i]));
            end else begin
                chk(init_h == -1, "R2 R5 no init grant", init_h, -1);
                chk(cnt_w[0] == 0, "R5 no early resync", cnt_w[0], 0);
            end
            // R4: run grant on visible lines
            if (TV_ER[i] != 0) begin
                exp_g = first_slot(1106);
                chk(run_h == exp_g, "R4 R1 run grant position", run_h, exp_g);
                chk(cnt_w[2] == resync_of(1106, exp_g, TV_CYC[i]), "R7 run stall length", cnt_w[2],
                    resync_of(1106, exp_g, TV_CYC[i]));
            end else begin
                chk(run_h == -1, "R4 R5 no run grant", run_h, -1);
                chk(cnt_w[2] == 0, "R5 no late resync", cnt_w[2], 0);
            end
            // R3: refresh position and length
            exp_ref = (TV_REV[i] != 0) ? 538 - p : 530;
            chk(ref_h == exp_ref, "R3 refresh position", ref_h, exp_ref);
            chk(ref_n == 40, "R3 refresh length", ref_n, 40);
        end

        // R6: DMA alone, channels enabled
        begin
            int g;
            run_line(300, 0, 0, 1364, 1, 1, 1, 8, 200, 0);
            g = first_slot(201);
            chk(dma_h == g, "R6 R1 dma grant position", dma_h, g);
            chk(cnt_w[1] == resync_of(201, g, 8), "R7 dma stall length", cnt_w[1], resync_of(201, g, 8));
        end
        // R6: DMA requested with no channel enabled: no grant, run state leaves at once
        run_line(300, 0, 0, 1363, 1, 1, 0, 6, 200, 0);
        chk(dma_h == -1, "R6 dma disabled no grant", dma_h, -1);
        chk(cnt_w[1] == 5, "R7 empty run resync n=1", cnt_w[1], 5);
        // R6: HDMA run and DMA pending together: HDMA first, DMA 8 later
        begin
            int g1;
            run_line(100, 0, 1, 1362, 1, 1, 1, 12, 1105, 0);
            g1 = first_slot(1106);
            chk(run_h == g1, "R6 hdma first", run_h, g1);
            chk(dma_h == g1 + 8, "R6 dma after hdma", dma_h, g1 + 8);
            chk(cnt_w[2] == resync_of(1106, g1 + 8, 12), "R7 chained stall length", cnt_w[2],
                resync_of(1106, g1 + 8, 12));
        end
        // R5: init event held until the first cycle edge at position 100
        begin
            int g;
            run_line(0, 0, 1, 1364, 1, 1, 0, 8, -1, 100);
            g = first_slot(101);
            chk(init_h == g, "R5 init held until edge", init_h, g);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule